// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Controller

This block is the digital core of a power supervisor. It watches one combined undervoltage flag and one watchdog input. It drives two active-low outputs: a system reset and a watchdog fault flag. Every timing step is counted in ticks of an external timebase strobe, so one clock can serve slow, millisecond-scale periods.

An undervoltage holds the system reset low. When the undervoltage ends, the reset stays low for one more reset-hold period. Once the reset is released, the processor must toggle the watchdog input within each watchdog period. If it misses a period, the block pulses the reset low for one reset-hold period and latches the fault flag low. After the reset, software reads the flag to tell a watchdog reset from an undervoltage reset, and any toggle clears the flag.

A watchdog input that is floating freezes the timer but leaves the flag as it is. A disable strap stops the watchdog from ever expiring. The two periods are taken from configuration ports while the block's own reset is held. A watchdog setting of zero selects ten times the reset-hold period.

Top module: `supv_rst_wdog`

## Requirements
- R1: While `rst_n` is low, `sys_rst_n_o` is 0 and `wdo_n_o` is 1. The period ports are captured only while `rst_n` is low; changing them afterwards has no effect.
- R2: A clock edge that samples `uv_i` high sets `sys_rst_n_o` to 0 and `wdo_n_o` to 1, and clears the watchdog count.
- R3: After `uv_i` falls, or after `rst_n` rises, with `tick_i` held high, `sys_rst_n_o` rises on the L-th clock edge, where L is the captured reset-hold setting.
- R4: The watchdog count starts when the reset is released. With `tick_i` high, on the W-th edge after the release, `sys_rst_n_o` and `wdo_n_o` both go to 0 on that same edge.
- R5: Either a rising or a falling change of `wdi_i` restarts the watchdog period. The restart, and any clearing of the fault, takes effect on the third clock edge after the change: two synchronizer stages, then one compare stage.
- R6: While `sys_rst_n_o` is 0, changes of `wdi_i` have no effect. `wdo_n_o` keeps its value, and the reset timing is not altered.
- R7: Once `wdo_n_o` is 0, it stays 0 until one of two events. Either a `wdi_i` change is acted on while the reset is released, or an undervoltage occurs.
- R8: If the fault is never cleared, the outputs keep cycling. The reset is low for L ticks and high for W ticks, and `wdo_n_o` stays 0 throughout.
- R9: While `wdi_float_i` is 1, the watchdog count is held at zero, `wdi_i` changes are not acted on, and `wdo_n_o` is unchanged. After the input falls to 0, a full W-tick period runs before expiry.
- R10: While `wd_dis_i` is 1, the watchdog never expires and `wdo_n_o` stays 1 after an undervoltage.
- R11: A `wd_ticks_i` value of 0 selects W = 10·L. A `rst_ticks_i` value of 0 is treated as 1.
- R12: Both counts advance only on edges where `tick_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Block reset, active low; the period ports are captured while it is low |
| tick_i | input | 1 | Timebase strobe; one tick per high cycle |
| uv_i | input | 1 | Combined undervoltage flag, active high |
| wdi_i | input | 1 | Watchdog input level, asynchronous |
| wdi_float_i | input | 1 | High while the watchdog input is floating |
| wd_dis_i | input | 1 | Watchdog disable strap |
| rst_ticks_i | input | CW | Reset-hold period L in ticks |
| wd_ticks_i | input | CW+4 | Watchdog period W in ticks; 0 selects 10·L |
| sys_rst_n_o | output | 1 | System reset, active low |
| wdo_n_o | output | 1 | Watchdog fault flag, active low, latched |

## Verification
Each result is due a fixed number of clock edges after its stimulus. An undervoltage shows on both outputs one edge later. The reset release comes L edges after the undervoltage falls or `rst_n` rises. Expiry comes W edges after the release or after a float ends. A watchdog-input change is acted on at the third edge. The driver computes each due cycle from these rules when it applies a stimulus and queues the expected output values with that cycle. The monitor samples a quarter period after each rising edge and compares the queued items exactly on their due cycle. It also checks the cycle just before each expected change, so an early result is reported as well as a late one.

// File: rtl/supv_pkg.sv
package supv_pkg;
  // Multiplier applied to the reset-hold period when no watchdog period is set
  localparam int unsigned WD_DEFAULT_MULT = 10;
  // Extra width of the watchdog count over the configuration width
  localparam int unsigned WD_EXTRA_W = 4;
endpackage

// File: rtl/supv_wdi_sync.sv
module supv_wdi_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic wdi_i,
  input  logic float_i,
  output logic edge_o
);
  // stage[0], stage[1]: synchronizer; stage[2]: previous synchronized level
  logic [2:0] stage;

  always_ff @(posedge clk) begin
    if (!rst_n) stage <= '0;
    else        stage <= {stage[1:0], wdi_i};
  end

  assign edge_o = (stage[2] ^ stage[1]) & ~float_i;
endmodule

// File: rtl/supv_rst_stretch.sv
module supv_rst_stretch #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          hold_i,
  input  logic          trip_i,
  input  logic [CW-1:0] limit_i,
  output logic          low_o
);
  logic [CW-1:0] cnt_q;
  logic          low_q;
  logic          done;

  assign done  = low_q && tick_i && (cnt_q == limit_i - CW'(1));
  assign low_o = low_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_q <= 1'b1;
      cnt_q <= '0;
    end else if (hold_i || trip_i) begin
      low_q <= 1'b1;
      cnt_q <= '0;
    end else if (low_q && tick_i) begin
      if (done) begin
        low_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assert_uv_holds_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> low_q);
  assert_trip_asserts_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trip_i |=> (low_q && cnt_q == '0));
  assert_count_frozen_no_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !hold_i && !trip_i) |=> ($stable(cnt_q) && $stable(low_q)));
endmodule

// File: rtl/supv_wd_timer.sv
module supv_wd_timer #(
  parameter int unsigned WW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          run_i,
  input  logic          clr_i,
  input  logic [WW-1:0] limit_i,
  output logic          expire_o
);
  logic [WW-1:0] cnt_q;

  assign expire_o = run_i && !clr_i && tick_i && (cnt_q == limit_i - WW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)                             cnt_q <= '0;
    else if (!run_i || clr_i || expire_o)   cnt_q <= '0;
    else if (tick_i)                        cnt_q <= cnt_q + WW'(1);
  end

  assert_stopped_timer_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0));
  assert_edge_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
  assert_timer_frozen_no_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !clr_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/supv_rst_wdog.sv
module supv_rst_wdog #(
  parameter int unsigned CW = 16,
  localparam int unsigned WW = CW + supv_pkg::WD_EXTRA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          uv_i,
  input  logic          wdi_i,
  input  logic          wdi_float_i,
  input  logic          wd_dis_i,
  input  logic [CW-1:0] rst_ticks_i,
  input  logic [WW-1:0] wd_ticks_i,
  output logic          sys_rst_n_o,
  output logic          wdo_n_o
);
  // Effective reset-hold period: zero is raised to one tick
  function automatic logic [CW-1:0] eff_reset(input logic [CW-1:0] r);
    return (r == '0) ? CW'(1) : r;
  endfunction

  // Effective watchdog period: zero selects the default multiple of the reset hold
  function automatic logic [WW-1:0] eff_watchdog(input logic [CW-1:0] r,
                                                 input logic [WW-1:0] w);
    logic [WW-1:0] base;
    base = WW'(eff_reset(r));
    return (w == '0) ? base * WW'(supv_pkg::WD_DEFAULT_MULT) : w;
  endfunction

  logic [CW-1:0] rst_lim_q;
  logic [WW-1:0] wd_lim_q;
  logic          rst_low;
  logic          wdi_edge;
  logic          wd_run;
  logic          wd_expire;
  logic          wdo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_lim_q <= eff_reset(rst_ticks_i);
      wd_lim_q  <= eff_watchdog(rst_ticks_i, wd_ticks_i);
    end
  end

  supv_wdi_sync u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .wdi_i   (wdi_i),
    .float_i (wdi_float_i),
    .edge_o  (wdi_edge)
  );

  supv_rst_stretch #(.CW(CW)) u_stretch (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .hold_i  (uv_i),
    .trip_i  (wd_expire),
    .limit_i (rst_lim_q),
    .low_o   (rst_low)
  );

  assign wd_run = !rst_low && !uv_i && !wdi_float_i && !wd_dis_i;

  supv_wd_timer #(.WW(WW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .run_i    (wd_run),
    .clr_i    (wdi_edge),
    .limit_i  (wd_lim_q),
    .expire_o (wd_expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                      wdo_q <= 1'b1;
    else if (uv_i)                   wdo_q <= 1'b1;
    else if (wd_expire)              wdo_q <= 1'b0;
    else if (wdi_edge && !rst_low)   wdo_q <= 1'b1;
  end

  assign sys_rst_n_o = !rst_low;
  assign wdo_n_o     = wdo_q;

  assert_uv_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    uv_i |=> (wdo_n_o && !sys_rst_n_o));
  assert_expiry_pulls_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> (!wdo_n_o && !sys_rst_n_o));
  assert_edges_ignored_in_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_low && !uv_i) |=> $stable(wdo_n_o));
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdo_n_o && !uv_i && !wdi_edge) |=> !wdo_n_o);
  assert_float_keeps_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wdi_float_i && !uv_i) |=> $stable(wdo_n_o));
  assert_disable_never_expires_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wd_dis_i |-> !wd_expire);
endmodule

// File: tb/supv_rst_wdog_tb.sv
module supv_rst_wdog_tb_top;
  localparam int unsigned CW = 16;
  localparam int unsigned WW = CW + 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_i = 1'b1;
  logic          uv_i = 1'b0;
  logic          wdi_i = 1'b0;
  logic          wdi_float_i = 1'b0;
  logic          wd_dis_i = 1'b0;
  logic [CW-1:0] rst_ticks_i = CW'(5);
  logic [WW-1:0] wd_ticks_i = WW'(12);
  logic          sys_rst_n_o;
  logic          wdo_n_o;

  supv_rst_wdog #(.CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .uv_i(uv_i), .wdi_i(wdi_i),
    .wdi_float_i(wdi_float_i), .wd_dis_i(wd_dis_i), .rst_ticks_i(rst_ticks_i),
    .wd_ticks_i(wd_ticks_i), .sys_rst_n_o(sys_rst_n_o), .wdo_n_o(wdo_n_o)
  );

  always #10 clk = ~clk; // 50 MHz

  typedef struct {
    int    at;
    bit    rst;
    bit    wdo;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   n_checks = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  // Driver side: queue an expected output pair for the cycle now + dly
  task automatic expect_at(input int dly, input bit r, input bit w, input string req);
    exp_t e;
    e.at = cyc + dly; e.rst = r; e.wdo = w; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: sample a quarter period after each rising edge
  always @(posedge clk) begin
    #5;
    cyc = cyc + 1;
    for (int i = exp_q.size() - 1; i >= 0; i--) begin
      if (exp_q[i].at == cyc) begin
        n_checks++;
        if (sys_rst_n_o !== exp_q[i].rst || wdo_n_o !== exp_q[i].wdo) begin
          n_fail++;
          $display("FAIL %s cyc %0d: rst=%b wdo=%b expected rst=%b wdo=%b",
                   exp_q[i].req, cyc, sys_rst_n_o, wdo_n_o, exp_q[i].rst, exp_q[i].wdo);
        end
        exp_q.delete(i);
      end
    end
  end

  initial begin : watchdog
    int limit;
    limit = 5000;
    while (cyc < limit && !done) @(negedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired at cyc %0d: expected end of test", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : driver
    int L, W, t;
    L = 5; W = 12;
    step(3);
    // R1: held in reset
    expect_at(1, 1'b0, 1'b1, "R1");
    step(2);
    rst_n = 1'b1;
    // R3: release after L ticks; R4: expiry W ticks later
    expect_at(L - 1, 1'b0, 1'b1, "R3");
    expect_at(L, 1'b1, 1'b1, "R3");
    expect_at(L + W - 1, 1'b1, 1'b1, "R4");
    expect_at(L + W, 1'b0, 1'b0, "R4");
    step(L + W);
    // R6: change wdi while reset is low (acted on at +3, still in reset)
    wdi_i = 1'b1;
    expect_at(3, 1'b0, 1'b0, "R6");
    expect_at(L - 1, 1'b0, 1'b0, "R6");
    expect_at(L, 1'b1, 1'b0, "R6");
    // R8 / R7: uncleared fault cycles again
    expect_at(L + W - 1, 1'b1, 1'b0, "R7");
    expect_at(L + W, 1'b0, 1'b0, "R8");
    expect_at(2 * L + W, 1'b1, 1'b0, "R8");
    step(2 * L + W + 2);
    // R5 / R7: falling change after release clears the flag and restarts
    t = cyc;
    wdi_i = 1'b0;
    expect_at(2, 1'b1, 1'b0, "R5");
    expect_at(3, 1'b1, 1'b1, "R7");
    expect_at(W - 2, 1'b1, 1'b1, "R5");
    expect_at(W + 2, 1'b1, 1'b1, "R5");
    expect_at(W + 3, 1'b0, 1'b0, "R5");
    step(W + 4);
    // R2: undervoltage while in fault
    uv_i = 1'b1;
    expect_at(1, 1'b0, 1'b1, "R2");
    expect_at(15, 1'b0, 1'b1, "R2");
    step(20);
    uv_i = 1'b0;
    expect_at(L - 1, 1'b0, 1'b1, "R3");
    expect_at(L, 1'b1, 1'b1, "R3");
    step(L + 2);
    // R9: float freezes timer; rising change during float not acted on
    wdi_float_i = 1'b1;
    step(2);
    wdi_i = 1'b1;
    expect_at(28, 1'b1, 1'b1, "R9");
    step(30);
    wdi_float_i = 1'b0;
    expect_at(W - 1, 1'b1, 1'b1, "R9");
    expect_at(W, 1'b0, 1'b0, "R9");
    step(W + L + 1);
    // R9: float with flag low keeps it low, then full period after float ends
    wdi_float_i = 1'b1;
    step(2);
    wdi_i = 1'b0;
    expect_at(10, 1'b1, 1'b0, "R9");
    step(20);
    wdi_float_i = 1'b0;
    expect_at(W - 1, 1'b1, 1'b0, "R9");
    expect_at(W, 1'b0, 1'b0, "R9");
    step(W + 1);
    // R10: disable strap, undervoltage sets flag, no expiry afterwards
    wd_dis_i = 1'b1;
    uv_i = 1'b1;
    step(2);
    uv_i = 1'b0;
    expect_at(L, 1'b1, 1'b1, "R10");
    expect_at(L + 3 * W, 1'b1, 1'b1, "R10");
    step(L + 3 * W + 2);
    // R12: counts only advance on tick
    uv_i = 1'b1;
    step(1);
    uv_i = 1'b0;
    tick_i = 1'b0;
    expect_at(20, 1'b0, 1'b1, "R12");
    step(22);
    tick_i = 1'b1;
    expect_at(L - 1, 1'b0, 1'b1, "R12");
    expect_at(L, 1'b1, 1'b1, "R12");
    step(L + 2);
    // R11 / R1: new config in reset, W defaults to 10*L, later port changes ignored
    wd_dis_i = 1'b0;
    rst_n = 1'b0;
    rst_ticks_i = CW'(4);
    wd_ticks_i = '0;
    expect_at(2, 1'b0, 1'b1, "R1");
    step(3);
    rst_n = 1'b1;
    L = 4; W = 40;
    expect_at(L, 1'b1, 1'b1, "R1");
    expect_at(L + W - 1, 1'b1, 1'b1, "R11");
    expect_at(L + W, 1'b0, 1'b0, "R11");
    expect_at(2 * L + W - 1, 1'b0, 1'b0, "R1");
    expect_at(2 * L + W, 1'b1, 1'b0, "R1");
    step(1);
    rst_ticks_i = CW'(9);
    wd_ticks_i = WW'(3);
    step(2 * L + W + 3);
    // R11: zero reset-hold setting treated as one tick
    rst_n = 1'b0;
    rst_ticks_i = '0;
    wd_ticks_i = WW'(6);
    step(2);
    rst_n = 1'b1;
    expect_at(1, 1'b1, 1'b1, "R11");
    expect_at(7, 1'b0, 1'b0, "R11");
    step(10);
    if (exp_q.size() != 0) begin
      n_fail += exp_q.size();
      $display("FAIL end: %0d expected items never compared, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule